// File: doc/BRIEF.md
# Cascaded 16-bit Timer/Event Counter

This block is a 16-bit up-counter made of two cascaded byte registers. A free-running prescaler divides the core clock into peripheral-cycle strobes, one every `PRESCALE` clocks. The counter can advance on each strobe (timer mode). It can also advance on falling edges of an external input that is sampled once per strobe (event mode). An edge counts only when a sample of 1 is followed by a sample of 0. Because of this, the fastest countable input changes level every peripheral cycle, which gives at most one count per two peripheral cycles.

When the 16-bit value wraps from 0xFFFF to 0x0000, a sticky overflow flag is set. It stays set until software pulses a clear strobe. Software may preset either byte through a shared data bus, but only while the run control is low. Byte loads made while running are dropped, so the count sequence stays deterministic.

Top module: `tmr16`

## Requirements
- R1: While `rst_n` is low, both count bytes and the overflow flag are 0, the input sample register holds 0, and the prescaler restarts. The first peripheral strobe falls on the `PRESCALE`-th rising clock edge after reset is released, and then on every `PRESCALE`-th edge, whatever the value of `run`.
- R2: With `run`=1 and `ext_mode`=0, the 16-bit value {`cnt_hi`,`cnt_lo`} increases by exactly one on every peripheral strobe. With the default `PRESCALE` of 12, that is one step per 12 clocks.
- R3: When the low byte steps from 0xFF to 0x00, the high byte increases by one on the same clock edge.
- R4: A step from 0xFFFF wraps the value to 0x0000 and sets `ovf_flag` on the same edge.
- R5: `ovf_flag` stays set until a clock edge at which `flag_clr` is 1. If an overflow and `flag_clr` coincide, the flag ends up set.
- R6: While `run`=0, `ld_lo` copies `ld_data` into `cnt_lo` and `ld_hi` copies `ld_data` into `cnt_hi` at the next clock edge. Both strobes together load the same byte into both halves.
- R7: While `run`=1, `ld_lo` and `ld_hi` are ignored. The value changes only by its normal +1 steps.
- R8: Raising or lowering `run` does not change the count. While `run`=0 and no load strobe is active, the value holds.
- R9: With `ext_mode`=1, `ext_pin` is sampled only on peripheral strobes. The value increases by one on the strobe whose sample is 0 when the previous sample was 1. Level changes between two strobes are not seen.
- R10: An `ext_pin` that alternates 1,0,1,0 on successive strobes produces one count per two strobes, which is the highest event rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run control: 1 lets the counter advance |
| ext_mode | input | 1 | 0 counts peripheral strobes, 1 counts falling edges on `ext_pin` |
| ext_pin | input | 1 | External event input |
| ld_data | input | BYTE_W | Preset data for either byte |
| ld_lo | input | 1 | Load low byte from `ld_data` (only while stopped) |
| ld_hi | input | 1 | Load high byte from `ld_data` (only while stopped) |
| flag_clr | input | 1 | Clears the overflow flag |
| cnt_lo | output | BYTE_W | Low count byte |
| cnt_hi | output | BYTE_W | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every result is a register, so loads, steps, byte carries, flag sets and flag clears show up one clock edge after the inputs that cause them. In event mode, the step appears one edge after the strobe that takes the low sample, which is `PRESCALE` clocks after the high sample. The bench drives inputs on the falling clock edge. A behavioural reference model advances on each rising edge from those held inputs, and outputs are compared with it on the following falling edge. Directed checks line up event-input changes with the model's own prescaler phase, so each level is in place before the strobe that samples it. The same checks count strobes to confirm the 12-clock step spacing and the two-strobe edge rate.

// File: rtl/tmr16.sv
module tmr16 #(
  parameter int PRESCALE = 12,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ext_mode,
  input  logic              ext_pin,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre;
  logic          smp;

  wire strobe   = (pre == PRE_LAST);
  wire fall     = smp & ~ext_pin;
  wire step     = run & strobe & (ext_mode ? fall : 1'b1);
  wire lo_wrap  = &cnt_lo;
  wire hi_wrap  = &cnt_hi;
  wire wrap_all = step & lo_wrap & hi_wrap;
  wire can_load = ~run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pre <= '0;
    else if (strobe) pre <= '0;
    else             pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      smp <= 1'b0;
    else if (strobe) smp <= ext_pin;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt_lo <= '0;
    else if (can_load && ld_lo) cnt_lo <= ld_data;
    else if (step)              cnt_lo <= cnt_lo + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt_hi <= '0;
    else if (can_load && ld_hi) cnt_hi <= ld_data;
    else if (step && lo_wrap)   cnt_hi <= cnt_hi + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap_all) ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              ld_lo,
  input logic              ld_hi,
  input logic [BYTE_W-1:0] ld_data,
  input logic              flag_clr,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              ovf_flag
);
  wire [2*BYTE_W-1:0] val = {cnt_hi, cnt_lo};

  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> $stable(val));

  p_load_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && ld_lo) |=> (cnt_lo == $past(ld_data)));

  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(val)) |-> (val == $past(val) + 1'b1));

  p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (val == '0 && $past(val) == '1));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);
endmodule

bind tmr16 tmr16_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .ld_lo(ld_lo), .ld_hi(ld_hi),
  .ld_data(ld_data), .flag_clr(flag_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .ovf_flag(ovf_flag)
);

// File: tb/sim_tmr16.sv
module sim_tmr16;
  localparam int CLK_PERIOD = 10;
  localparam int P = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, ext_mode = 1'b0, ext_pin = 1'b0;
  logic [7:0] ld_data = 8'h00;
  logic ld_lo = 1'b0, ld_hi = 1'b0, flag_clr = 1'b0;
  logic [7:0] cnt_lo, cnt_hi;
  logic ovf_flag;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit finished = 1'b0;

  int mpre = 0, msmp = 0, mcnt = 0, mflag = 0;

  tmr16 #(.PRESCALE(P), .BYTE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .ext_mode(ext_mode), .ext_pin(ext_pin),
    .ld_data(ld_data), .ld_lo(ld_lo), .ld_hi(ld_hi), .flag_clr(flag_clr),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, advanced on each rising edge from held inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      mpre = 0; msmp = 0; mcnt = 0; mflag = 0;
    end else begin
      bit st, inc, wrap;
      st = (mpre == P-1);
      mpre = st ? 0 : mpre + 1;
      inc = run && st && (ext_mode ? (msmp == 1 && ext_pin == 1'b0) : 1'b1);
      wrap = inc && (mcnt == 65535);
      if (!run) begin
        if (ld_lo) mcnt = (mcnt & 32'hFF00) | int'(ld_data);
        if (ld_hi) mcnt = (mcnt & 32'h00FF) | (int'(ld_data) << 8);
      end else if (inc) mcnt = (mcnt + 1) % 65536;
      if (wrap) mflag = 1;
      else if (flag_clr) mflag = 0;
      if (st) msmp = int'(ext_pin);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check("R2/R3/R9 model count", int'({cnt_hi, cnt_lo}), mcnt);
      check("R4/R5 model flag", int'(ovf_flag), mflag);
    end
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int val();
    return int'({cnt_hi, cnt_lo});
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load16(input int v);
    @(negedge clk);
    ld_data = v[7:0]; ld_lo = 1'b1;
    @(negedge clk);
    ld_lo = 1'b0; ld_data = v[15:8]; ld_hi = 1'b1;
    @(negedge clk);
    ld_hi = 1'b0;
  endtask

  // set pin so that the next strobe samples v, then pass that strobe
  task automatic samp(input logic v);
    @(negedge clk);
    while (mpre != P-1) @(negedge clk);
    ext_pin = v;
    @(negedge clk);
  endtask

  task automatic wait_change();
    int old;
    old = val();
    for (int i = 0; i < 4*P && val() == old; i++) @(negedge clk);
  endtask

  initial begin
    int v0;
    tick(3);
    check("R1 reset count", val(), 0);
    check("R1 reset flag", int'(ovf_flag), 0);
    rst_n = 1'b1;

    load16(16'hFFFE);
    check("R6 load both bytes", val(), 16'hFFFE);
    tick(30);
    check("R8 hold while stopped", val(), 16'hFFFE);

    @(negedge clk); run = 1'b1;
    @(negedge clk);
    check("R8 run rise keeps count", val(), 16'hFFFE);
    wait_change();
    check("R2 first step", val(), 16'hFFFF);
    tick(P-1);
    check("R2 no step before 12 clocks", val(), 16'hFFFF);
    tick(1);
    check("R4 wrap to zero", val(), 0);
    check("R4 flag set on wrap", int'(ovf_flag), 1);
    tick(20);
    check("R5 flag sticky", int'(ovf_flag), 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R5 flag cleared", int'(ovf_flag), 0);

    v0 = val();
    @(negedge clk); ld_data = 8'h55; ld_lo = 1'b1; ld_hi = 1'b1;
    @(negedge clk); ld_lo = 1'b0; ld_hi = 1'b0;
    check("R7 load ignored while running", int'(val() == v0 || val() == v0 + 1), 1);

    @(negedge clk); run = 1'b0;
    v0 = val();
    tick(2);
    check("R8 run fall keeps count", val(), v0);
    load16(16'h00FF);
    run = 1'b1;
    wait_change();
    check("R3 low byte carry into high", val(), 16'h0100);

    @(negedge clk); run = 1'b0;
    load16(16'hFFFF);
    flag_clr = 1'b1; run = 1'b1;
    while (val() != 0) @(negedge clk);
    check("R5 set wins over clear", int'(ovf_flag), 1);
    @(negedge clk);
    check("R5 clear next cycle", int'(ovf_flag), 0);
    flag_clr = 1'b0;

    @(negedge clk); run = 1'b0;
    load16(0);
    ext_mode = 1'b1; run = 1'b1;
    samp(1'b0);
    samp(1'b1);
    check("R9 no count on rising sample", val(), 0);
    samp(1'b0);
    check("R9 count on 1 then 0", val(), 1);
    samp(1'b1); samp(1'b1); samp(1'b0); samp(1'b0);
    check("R9 one count per falling pair", val(), 2);
    for (int i = 0; i < 4; i++) begin samp(1'b1); samp(1'b0); end
    check("R10 alternating gives half rate", val(), 6);
    samp(1'b1);
    tick(3); ext_pin = 1'b0; tick(3); ext_pin = 1'b1;
    samp(1'b1);
    check("R9 glitch between samples unseen", val(), 6);
    samp(1'b0);
    check("R9 count after glitch test", val(), 7);

    tick(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule